// File: doc/BRIEF.md
# Asynchronous Rising-Edge Catcher

This block turns rising edges on a free-running input that has no clock of its own into single-cycle event pulses in the system clock domain. The input never passes through a sampling flop. Instead, its rising edge clocks a capture flop whose data input is tied to logic 1. Any edge therefore sets the flop, even when the input pulse is much narrower than a system clock period.

The capture flop is the only point where the input is sampled. Its output crosses into the system domain through a synchronizer chain clocked on the rising edge of the system clock. Only the last stage of the chain feeds other logic. A rising-edge detector on that stage produces the event pulse. A clear handshake then holds the capture flop cleared until the first synchronizer stage has seen the cleared value, and this re-arms the catcher.

The handshake creates a dead time after each captured edge. Edges that fall inside the dead time are absorbed without producing an event. With a 4 ns clock and input edges at least 33 ns apart, no edge falls inside it. Cycle numbers below apply to the default of two synchronizer stages. "Edge index k" of an input edge means the first rising clock edge after that input edge.

Top module: `async_edge_catcher`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `evt_o` is low in the following cycle, and the capture flop is held cleared. An input edge that arrives during reset produces no event after reset is released.
- R2: A rising edge of `async_in` is captured whatever its pulse width, including a high time of well under one clock period (0.3 ns at a 4 ns clock).
- R3: An accepted input edge with edge index k makes `evt_o` high in exactly the clock cycle that begins at clock edge k+1. This is at most three clock periods after the input edge.
- R4: Each accepted input edge gives exactly one `evt_o` pulse, one clock cycle wide. An input held high for many cycles gives one pulse only.
- R5: After an accepted edge with index k, any further input edge with index k+1 to k+5 is ignored: it produces no `evt_o` pulse.
- R6: An input edge with index k+6 or later after the previous accepted edge is accepted. As a result, edges spaced 33 ns or more apart (at a 4 ns clock) are never lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every synchronous flop uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| async_in | input | 1 | Free-running asynchronous input; its rising edges are caught |
| evt_o | output | 1 | One-cycle event pulse per accepted input edge |

## Verification
Each input edge is launched a fixed fraction of a period after a rising clock edge, so the bench knows its edge index k. The bench model then expects the pulse only in the cycle that starts at clock edge k+1, and expects a clean low everywhere else. Outputs are sampled on the falling clock edge, mid-cycle, and compared with the model on every cycle, so an early, late, doubled or missing pulse is caught in the exact cycle where it occurs. The model accepts an edge only when its index is at least six beyond the previous accepted one. Directed edges are placed at offsets of one, five and six cycles to probe both sides of that dead-time limit.

// File: rtl/ec_pkg.sv
`timescale 1ns/1ps
// Package: ec_pkg
// Shared definitions for the asynchronous edge catcher.
// Assumes: nothing beyond standard SystemVerilog.
package ec_pkg;

    // Smallest synchronizer depth that still gives a full cycle of settling.
    localparam int EC_MIN_SYNC = 2;

    // State of the capture-flop clear handshake.
    typedef enum logic {
        CLR_ARMED = 1'b0,
        CLR_HOLD  = 1'b1
    } ec_clr_e;

endpackage

// File: rtl/ec_capture_flop.sv
`timescale 1ns/1ps
// Module: ec_capture_flop
// What it does: the asynchronous input clocks this flop with its data input
// tied high, so any rising edge sets it, however short the pulse is.
// Assumes: clr_i comes from a flop in the system domain, so it has no glitches.
// The output goes to exactly one synchronizer input and nowhere else.
module ec_capture_flop (
    input  logic async_in,
    input  logic clr_i,
    output logic cap_o
);

    logic cap_q;

    // Set on an input rising edge; the clear is asynchronous and wins.
    always_ff @(posedge async_in or posedge clr_i) begin
        if (clr_i) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= 1'b1;
        end
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/ec_sync_chain.sv
`timescale 1ns/1ps
// Module: ec_sync_chain
// What it does: a shift chain of STAGES flops, all on the rising clock edge,
// that carries the capture level into the system domain.
// Assumes: STAGES >= 2. Only last_o may fan out to data logic; first_o goes
// to the clear handshake alone.
module ec_sync_chain #(
    parameter int STAGES = ec_pkg::EC_MIN_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic first_o,
    output logic last_o
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] stg_q;

    // Shift the captured level one stage per clock; reset empties the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[TOP-1:0], d_i};
        end
    end

    assign first_o = stg_q[0];
    assign last_o  = stg_q[TOP];

endmodule

// File: rtl/ec_clear_ctrl.sv
`timescale 1ns/1ps
// Module: ec_clear_ctrl
// What it does: drives the capture-flop clear. The clear is raised once the
// last synchronizer stage is high. It is dropped once both the last stage and
// the first stage read low, which proves the cleared value has reached the
// synchronizer input.
// Assumes: synchronous active-low reset. Reset holds the clear asserted.
module ec_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic first_i,
    input  logic last_i,
    output logic clr_o
);

    import ec_pkg::*;

    ec_clr_e st_q;

    // Handshake state: hold the clear after a transfer, re-arm once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CLR_HOLD;
        end else if (last_i) begin
            st_q <= CLR_HOLD;
        end else if (!first_i) begin
            st_q <= CLR_ARMED;
        end
    end

    assign clr_o = (st_q == CLR_HOLD);

    AST_RESET_HOLDS_CLEAR: assert property (@(posedge clk)
        !rst_n |=> clr_o); // R1

    AST_CLEAR_AFTER_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> clr_o); // R5

    AST_REARM_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_i && !first_i) |=> !clr_o); // R6

endmodule

// File: rtl/ec_edge_pulse.sv
`timescale 1ns/1ps
// Module: ec_edge_pulse
// What it does: turns a low-to-high step of a synchronous level into a pulse
// one clock cycle wide.
// Assumes: lvl_i is already in the clk domain.
module ec_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);

    logic dly_q;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= 1'b0;
        end else begin
            dly_q <= lvl_i;
        end
    end

    assign pulse_o = lvl_i & ~dly_q;

    AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R4

endmodule

// File: rtl/async_edge_catcher.sv
`timescale 1ns/1ps
// Module: async_edge_catcher
// What it does: catches rising edges of an unclocked input and reports each
// one as a single-cycle pulse in the clk domain. The data path is capture
// flop, then synchronizer chain, then edge pulse. A clear handshake re-arms
// the capture flop after each transfer.
// Assumes: input edges come at least six clock periods apart if all of them
// must be reported. Edges closer than that are absorbed by the dead time.
module async_edge_catcher #(
    parameter int SYNC_STAGES = ec_pkg::EC_MIN_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic evt_o
);

    logic cap;
    logic clr;
    logic sync_first;
    logic sync_last;

    // Single sampling point of the asynchronous input.
    ec_capture_flop u_cap (
        .async_in (async_in),
        .clr_i    (clr),
        .cap_o    (cap)
    );

    // Same-edge synchronizer into the clk domain.
    ec_sync_chain #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (cap),
        .first_o (sync_first),
        .last_o  (sync_last)
    );

    // Re-arm handshake for the capture flop.
    ec_clear_ctrl u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_i (sync_first),
        .last_i  (sync_last),
        .clr_o   (clr)
    );

    // One pulse per synchronized rising step.
    ec_edge_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (sync_last),
        .pulse_o (evt_o)
    );

    AST_NO_EVENT_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !evt_o); // R1

    AST_EVENT_STARTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> clr); // R5

    AST_NO_EVENT_WHILE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !sync_first) |=> !evt_o); // R3

endmodule

// File: tb/test_async_edge_catcher.sv
`timescale 1ns/1ps
module test_async_edge_catcher;

    logic clk      = 1'b0;
    logic rst_n    = 1'b0;
    logic async_in = 1'b0;
    logic evt_o;

    int cyc       = 0;
    int errors    = 0;
    int checks    = 0;
    int last_k    = -100;
    int got_evts  = 0;
    int exp_evts  = 0;
    bit model_on  = 1'b0;
    int exp_q[$];

    async_edge_catcher i_async_edge_catcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (async_in),
        .evt_o    (evt_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Model: an edge with index k is accepted when k >= last accepted + 6 (R5, R6);
    // its pulse is due in the cycle starting at clock edge k+1 (R3).
    function automatic void note_edge();
        int k;
        k = cyc + 1;
        if (model_on && (k >= last_k + 6)) begin
            exp_q.push_back(k + 1);
            last_k = k;
            exp_evts++;
        end
    endfunction

    task automatic edge_at(input realtime off, input realtime width);
        @(posedge clk);
        #(off);
        async_in = 1'b1;
        note_edge();
        #(width);
        async_in = 1'b0;
    endtask

    // Compare against the model on every cycle, mid-cycle.
    always @(negedge clk) begin
        if (model_on) begin
            bit expv;
            expv = (exp_q.size() > 0) && (exp_q[0] == cyc);
            if (expv) void'(exp_q.pop_front());
            if (evt_o) got_evts++;
            if (expv)
                check(evt_o === 1'b1, "R2/R3/R6 missing or late event", int'(evt_o), 1);
            else
                check(evt_o === 1'b0, "R4/R5 unexpected event", int'(evt_o), 0);
        end
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state and an edge during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(evt_o === 1'b0, "R1 output low in reset", int'(evt_o), 0);
        edge_at(1.5, 1.0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(evt_o === 1'b0, "R1 no event from reset-time edge", int'(evt_o), 0);
        end
        model_on = 1'b1;

        // R2: very narrow pulse
        edge_at(1.0, 0.3);
        repeat (12) @(posedge clk);

        // R4: level held high for many cycles gives one pulse
        edge_at(2.0, 60.0);
        repeat (12) @(posedge clk);

        // R5: edge one index later (merged) and five later (cleared) are ignored
        edge_at(0.7, 0.5);
        edge_at(1.5, 0.5);
        repeat (12) @(posedge clk);
        edge_at(3.2, 0.5);
        repeat (4) @(posedge clk);
        edge_at(1.0, 0.5);
        repeat (12) @(posedge clk);

        // R6: edge six indices later is accepted
        edge_at(2.5, 0.5);
        repeat (5) @(posedge clk);
        edge_at(0.6, 0.5);
        repeat (12) @(posedge clk);

        // R6: train of edges 33 ns apart, phase drifting across the clock
        @(posedge clk);
        #0.5;
        for (int j = 0; j < 12; j++) begin
            async_in = 1'b1;
            note_edge();
            #1.0;
            async_in = 1'b0;
            #32.0;
        end
        repeat (12) @(posedge clk);
        @(negedge clk);

        check(got_evts == exp_evts, "R6 total event count", got_evts, exp_evts);
        check(exp_q.size() == 0, "R3 all due events seen", exp_q.size(), 0);
        check(exp_evts == 18, "R5/R6 accepted edge count", exp_evts, 18);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule